// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block interprets the write cycles presented to a small byte-wide NOR-style flash model and drives what that model returns on reads. Each qualified write carries an address and a data byte. The block collects these writes into multi-cycle command sequences: program, sector erase, erase suspend and resume, the identification mode and the reset command. It keeps the array contents in an on-chip byte store, where program and erase run as timed embedded operations. Each sector has a protect bit, which a side port writes.

Reads are sampled on `rd_en` and appear on `rd_data` one cycle later. Depending on the internal mode, the read returns one of three things: array data, a status byte, or identification data. The status byte reports progress through a complement bit and a toggling bit, and it flags a failed program with a timeout bit. A controller uses the block like a bare parallel flash: it issues unlock writes, then polls status until the embedded operation finishes.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode. Every byte of the array reads 0xFF, every sector is unprotected, `busy` is low and `rd_data` is 0x00. Reading needs no command. A read returns the byte at `rd_addr` in the cycle after `rd_en`.
- R2: A program starts after four writes: 0xAA to address 0x555, then 0x55 to 0x2AA, then 0xA0 to 0x555, then the data byte to the target address. Only address bits [10:0] are compared. `busy` is then high for PROG_CYC cycles. After that the target byte holds the old byte ANDed with the data.
- R3: A write whose address or data does not match the next expected step of a sequence returns the block to array-read mode, and no operation starts.
- R4: A write of 0xF0, at any address, returns the block to array-read mode from the idle state, from any unlock step before the last command byte, and from identification mode.
- R5: While a program or erase is running, every write is ignored, including 0xF0. The only exception is the suspend byte during an erase.
- R6: The write 0x90, sent after the two unlock writes, enters identification mode. In that mode, read-address bits [1:0] select what is returned: 00 gives MAN_ID, 01 gives DEV_ID, 10 gives 0x00 or 0x01 (the protect bit of the sector that address bits [10:9] select), and 11 gives 0x00. Writes other than 0xF0 leave the mode unchanged.
- R7: While `busy` is high, every read returns status. Bit 7 is the complement of bit 7 of the programmed data, or 0 during an erase. Bit 6 inverts on every status read. All other bits are 0.
- R8: A program whose data has a 1 where the old byte has a 0 ends in a failed state. In that state `busy` is low and reads return the status byte with bit 5 set, with bit 6 still toggling. Only 0xF0 leaves the failed state.
- R9: A sector erase follows this sequence: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in the sector. Address bits [10:9] select the sector. The erase writes 0xFF to every byte of the sector, one byte per cycle, with `busy` high. Other sectors are unchanged.
- R10: Writing 0xB0 during an erase suspends it and drops `busy`. Reads to the suspended sector then return 0x80 with bit 6 held. Reads to other sectors return array data. In the idle state, writing 0x30 resumes the erase, which finishes the remaining bytes. A program aimed at the suspended sector is ignored.
- R11: While an erase is suspended, a program to another sector runs normally. Afterwards the block returns to suspended-read behaviour.
- R12: When `prot_we` is high, the next clock edge sets the protect bit of sector `prot_sect` to `prot_set`. A program or erase aimed at a protected sector is ignored: `busy` stays low and the contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Qualified write cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data or command byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result, valid the cycle after rd_en |
| prot_we | input | 1 | Protect bit write strobe |
| prot_sect | input | SECT_W | Sector whose protect bit is written |
| prot_set | input | 1 | New protect bit value |
| busy | output | 1 | Embedded program or erase running |

## Verification
The bench runs a program that only clears bits, and a program that tries to set a cleared bit. The first shows the AND rule and the second shows the timeout flag. It also sends broken sequences: wrong data, a wrong unlock address, a command byte with no unlock, and 0xF0 inserted between unlock steps. These separate a silent abort from a partial acceptance. An erase is run with a reset written halfway through, and another erase is suspended, overlaid with a program in a neighbouring sector, and then resumed. Together they show that busy operations ignore reset, that suspended sectors report status and that the erase finishes the bytes it had not yet reached. Protect bits are checked in identification mode and against both program and erase.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 2,
  parameter int PROG_CYC = 8,
  parameter logic [7:0] MAN_ID = 8'h3C,
  parameter logic [7:0] DEV_ID = 8'hA7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              prot_we,
  input  logic [SECT_W-1:0] prot_sect,
  input  logic              prot_set,
  output logic              busy
);
  localparam int OFF_W = ADDR_W - SECT_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NSECT = 1 << SECT_W;
  localparam int CNT_W = $clog2(PROG_CYC + 1);

  typedef enum logic [3:0] {
    S_HOME, S_U1, S_U2, S_PGMW, S_ESU, S_EU1, S_EU2, S_AUTO, S_PROG, S_ERASE, S_FAIL
  } st_t;

  st_t               st;
  logic [7:0]        mem [DEPTH];
  logic [NSECT-1:0]  prot;
  logic              susp, tog;
  logic [SECT_W-1:0] esect;
  logic [OFF_W-1:0]  eoff;
  logic [CNT_W-1:0]  pcnt;
  logic [ADDR_W-1:0] paddr;
  logic [7:0]        pdata, rd_val, merged;

  wire [SECT_W-1:0] wsect = wr_addr[ADDR_W-1 -: SECT_W];
  wire [SECT_W-1:0] rsect = rd_addr[ADDR_W-1 -: SECT_W];
  wire at555   = wr_addr[10:0] == 11'h555;
  wire is_aa   = wr_en && at555 && wr_data == 8'hAA;
  wire is_55   = wr_en && wr_addr[10:0] == 11'h2AA && wr_data == 8'h55;
  wire is_f0   = wr_en && wr_data == 8'hF0;
  wire prog_ok = !prot[wsect] && !(susp && wsect == esect);
  wire stat_rd = st == S_PROG || st == S_ERASE || st == S_FAIL;

  assign busy   = st == S_PROG || st == S_ERASE;
  assign merged = mem[paddr] & pdata;

  always_comb begin
    rd_val = mem[rd_addr];
    case (st)
      S_AUTO:  case (rd_addr[1:0])
                 2'd0:    rd_val = MAN_ID;
                 2'd1:    rd_val = DEV_ID;
                 2'd2:    rd_val = {7'b0, prot[rsect]};
                 default: rd_val = 8'h00;
               endcase
      S_PROG:  rd_val = {~pdata[7], tog, 6'b0};
      S_FAIL:  rd_val = {~pdata[7], tog, 1'b1, 5'b0};
      S_ERASE: rd_val = {1'b0, tog, 6'b0};
      default: if (susp && rsect == esect) rd_val = {1'b1, tog, 6'b0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_HOME; susp <= 1'b0; tog <= 1'b0; esect <= '0; eoff <= '0;
      pcnt <= '0; paddr <= '0; pdata <= '0; rd_data <= '0; prot <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (prot_we) prot[prot_sect] <= prot_set;
      if (rd_en) begin
        rd_data <= rd_val;
        if (stat_rd) tog <= ~tog;
      end
      case (st)
        S_HOME: if (is_aa) st <= S_U1;
                else if (wr_en && susp && wr_data == 8'h30) begin
                  st <= S_ERASE; susp <= 1'b0;
                end
        S_U1:   if (wr_en) st <= is_55 ? S_U2 : S_HOME;
        S_U2:   if (wr_en) begin
                  if (at555 && wr_data == 8'hA0)               st <= S_PGMW;
                  else if (at555 && wr_data == 8'h90)          st <= S_AUTO;
                  else if (at555 && wr_data == 8'h80 && !susp) st <= S_ESU;
                  else                                         st <= S_HOME;
                end
        S_PGMW: if (wr_en) begin
                  if (prog_ok) begin
                    st <= S_PROG; paddr <= wr_addr; pdata <= wr_data; pcnt <= '0;
                  end else st <= S_HOME;
                end
        S_ESU:  if (wr_en) st <= is_aa ? S_EU1 : S_HOME;
        S_EU1:  if (wr_en) st <= is_55 ? S_EU2 : S_HOME;
        S_EU2:  if (wr_en) begin
                  if (wr_data == 8'h30 && !prot[wsect]) begin
                    st <= S_ERASE; esect <= wsect; eoff <= '0;
                  end else st <= S_HOME;
                end
        S_AUTO: if (is_f0) st <= S_HOME;
        S_PROG: if (pcnt == CNT_W'(PROG_CYC - 1)) begin
                  mem[paddr] <= merged;
                  st <= (merged != pdata) ? S_FAIL : S_HOME;
                end else pcnt <= pcnt + 1'b1;
        S_ERASE: if (wr_en && wr_data == 8'hB0) begin
                   susp <= 1'b1; st <= S_HOME;
                 end else begin
                   mem[{esect, eoff}] <= 8'hFF;
                   eoff <= eoff + 1'b1;
                   if (&eoff) st <= S_HOME;
                 end
        S_FAIL: if (is_f0) st <= S_HOME;
        default: st <= S_HOME;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 2,
  parameter int PROG_CYC = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [7:0]                wr_data,
  input logic                      rd_en,
  input logic [ADDR_W-1:0]         rd_addr,
  input logic [7:0]                rd_data,
  input logic                      busy,
  input logic [3:0]                st,
  input logic [(1<<SECT_W)-1:0]    prot,
  input logic [ADDR_W-SECT_W-1:0]  eoff,
  input logic [$clog2(PROG_CYC+1)-1:0] pcnt
);
  localparam logic [3:0] C_U1 = 4'd1, C_PGMW = 4'd3, C_AUTO = 4'd7,
                         C_PROG = 4'd8, C_ERASE = 4'd9, C_FAIL = 4'd10;

  assert_reset_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == 8'hF0 &&
    ((st == C_PROG && pcnt == '0 && PROG_CYC > 1) || (st == C_ERASE && !(&eoff)))
    |=> busy);

  assert_bad_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_U1 && wr_en && !(wr_data == 8'h55 && wr_addr[10:0] == 11'h2AA)
    |=> st == 4'd0);

  assert_reset_exits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data == 8'hF0 && !busy && st != C_FAIL && st != C_PGMW
    |=> st == 4'd0 && !busy);

  assert_autoselect_prot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && st == C_AUTO && rd_addr[1:0] == 2'd2
    |=> rd_data == {7'b0, $past(prot[rd_addr[ADDR_W-1 -: SECT_W]])});

  assert_protected_skip_R12: assert property (@(posedge clk) disable iff (!rst_n)
    st == C_PGMW && wr_en && prot[wr_addr[ADDR_W-1 -: SECT_W]] |=> !busy);

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && st == C_PROG && $past(rd_en) && $past(st) == C_PROG
    |=> rd_data[6] != $past(rd_data[6]));

  assert_fail_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && st == C_FAIL |=> rd_data[5] && !busy);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
  .st(st), .prot(prot), .eoff(eoff), .pcnt(pcnt)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int AW = 11, SW = 2, PC = 8, SECT_SZ = 512;
  localparam logic [7:0] MAN = 8'h3C, DEV = 8'hA7;
  localparam int M_HOME = 0, M_U1 = 1, M_U2 = 2, M_PGMW = 3, M_ESU = 4, M_EU1 = 5,
                 M_EU2 = 6, M_AUTO = 7, M_PROG = 8, M_ERASE = 9, M_FAIL = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, prot_we = 0, prot_set = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [SW-1:0] prot_sect = '0;
  logic [7:0] rd_data;
  logic busy;

  flash_cmd_seq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .prot_we(prot_we), .prot_sect(prot_sect), .prot_set(prot_set), .busy(busy));

  always #4 clk = ~clk;

  int vec = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  int md, mleft, mes, meoff, ws, rs;
  logic [7:0] mm [SECT_SZ*4];
  bit mp [4];
  bit msusp, mtog;
  logic [7:0] mpd, er, mold;
  int mpa;

  always @(posedge clk) begin
    if (!rst_n) begin
      md = M_HOME; msusp = 0; mtog = 0; er = 8'h00; mes = 0; meoff = 0;
      for (int i = 0; i < SECT_SZ*4; i++) mm[i] = 8'hFF;
      for (int i = 0; i < 4; i++) mp[i] = 0;
    end else begin
      ws = int'(wr_addr) / SECT_SZ;
      rs = int'(rd_addr) / SECT_SZ;
      if (rd_en) begin
        if (md == M_AUTO)
          er = (rd_addr % 4 == 0) ? MAN : (rd_addr % 4 == 1) ? DEV :
               (rd_addr % 4 == 2) ? {7'b0, mp[rs]} : 8'h00;
        else if (md == M_PROG)  er = {~mpd[7], mtog, 6'b0};
        else if (md == M_FAIL)  er = {~mpd[7], mtog, 6'b100000};
        else if (md == M_ERASE) er = {1'b0, mtog, 6'b0};
        else if (msusp && rs == mes) er = {1'b1, mtog, 6'b0};
        else er = mm[rd_addr];
        if (md == M_PROG || md == M_ERASE || md == M_FAIL) mtog = !mtog;
      end
      case (md)
        M_HOME: if (wr_en && wr_addr == 11'h555 && wr_data == 8'hAA) md = M_U1;
                else if (wr_en && msusp && wr_data == 8'h30) begin md = M_ERASE; msusp = 0; end
        M_U1: if (wr_en) md = (wr_addr == 11'h2AA && wr_data == 8'h55) ? M_U2 : M_HOME;
        M_U2: if (wr_en) begin
                if (wr_addr != 11'h555) md = M_HOME;
                else if (wr_data == 8'hA0) md = M_PGMW;
                else if (wr_data == 8'h90) md = M_AUTO;
                else if (wr_data == 8'h80 && !msusp) md = M_ESU;
                else md = M_HOME;
              end
        M_PGMW: if (wr_en) begin
                  if (mp[ws] || (msusp && ws == mes)) md = M_HOME;
                  else begin md = M_PROG; mpa = int'(wr_addr); mpd = wr_data; mleft = PC; end
                end
        M_ESU: if (wr_en) md = (wr_addr == 11'h555 && wr_data == 8'hAA) ? M_EU1 : M_HOME;
        M_EU1: if (wr_en) md = (wr_addr == 11'h2AA && wr_data == 8'h55) ? M_EU2 : M_HOME;
        M_EU2: if (wr_en) begin
                 if (wr_data == 8'h30 && !mp[ws]) begin md = M_ERASE; mes = ws; meoff = 0; end
                 else md = M_HOME;
               end
        M_AUTO: if (wr_en && wr_data == 8'hF0) md = M_HOME;
        M_PROG: begin
                  mleft = mleft - 1;
                  if (mleft == 0) begin
                    mold = mm[mpa];
                    mm[mpa] = mold & mpd;
                    md = ((mold & mpd) != mpd) ? M_FAIL : M_HOME;
                  end
                end
        M_ERASE: if (wr_en && wr_data == 8'hB0) begin msusp = 1; md = M_HOME; end
                 else begin
                   mm[mes*SECT_SZ + meoff] = 8'hFF;
                   if (meoff == SECT_SZ-1) begin meoff = 0; md = M_HOME; end
                   else meoff = meoff + 1;
                 end
        M_FAIL: if (wr_en && wr_data == 8'hF0) md = M_HOME;
        default: md = M_HOME;
      endcase
      if (prot_we) mp[prot_sect] = prot_set;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    vec++;
    if (rd_data !== er || busy !== (md == M_PROG || md == M_ERASE)) begin
      bad++;
      $display("FAIL %s model: rd_data=%h busy=%b expected rd_data=%h busy=%b",
               cur_req, rd_data, busy, er, (md == M_PROG || md == M_ERASE));
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] mask,
                    input logic [7:0] exp, input string req);
    rd_en = 1; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    chk(req, rd_data & mask, exp);
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic erase_cmd(input logic [AW-1:0] a);
    unlock(); wr(11'h555, 8'h80); unlock(); wr(a, 8'h30);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_prot(input int s, input bit v);
    prot_we = 1; prot_sect = SW'(s); prot_set = v;
    @(negedge clk);
    prot_we = 0;
  endtask

  initial begin
    #(8*150000);
    bad++;
    $display("FAIL watchdog: got hung run expected completion");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  logic b6;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    cur_req = "R1";
    chk("R1", rd_data, 8'h00);
    chk("R1", {7'b0, busy}, 8'h00);
    rd(11'h000, 8'hFF, 8'hFF, "R1");
    rd(11'h7FF, 8'hFF, 8'hFF, "R1");
    // R2 / R7
    cur_req = "R2";
    unlock(); wr(11'h555, 8'hA0); wr(11'h123, 8'h5A);
    chk("R7", {7'b0, busy}, 8'h01);
    rd(11'h123, 8'hBF, 8'h80, "R7");
    b6 = rd_data[6];
    rd(11'h456, 8'hBF, 8'h80, "R7");
    chk("R7", {7'b0, rd_data[6]}, {7'b0, ~b6});
    wait_idle();
    rd(11'h123, 8'hFF, 8'h5A, "R2");
    // R8 failed program
    cur_req = "R8";
    unlock(); wr(11'h555, 8'hA0); wr(11'h123, 8'h0F);
    wait_idle();
    rd(11'h123, 8'hBF, 8'hA0, "R8");
    chk("R8", {7'b0, busy}, 8'h00);
    wr(11'h555, 8'hAA);
    rd(11'h000, 8'h20, 8'h20, "R8");
    wr(11'h3FF, 8'hF0);
    rd(11'h123, 8'hFF, 8'h0A, "R2");
    // R3 wrong sequences
    cur_req = "R3";
    unlock(); wr(11'h555, 8'h12); wr(11'h200, 8'h77);
    rd(11'h200, 8'hFF, 8'hFF, "R3");
    wr(11'h555, 8'hAA); wr(11'h123, 8'h55); wr(11'h555, 8'hA0); wr(11'h201, 8'h00);
    rd(11'h201, 8'hFF, 8'hFF, "R3");
    wr(11'h555, 8'hA0); wr(11'h202, 8'h00);
    rd(11'h202, 8'hFF, 8'hFF, "R3");
    // R4 reset between cycles
    cur_req = "R4";
    wr(11'h555, 8'hAA); wr(11'h7AB, 8'hF0); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0);
    wr(11'h203, 8'h00);
    rd(11'h203, 8'hFF, 8'hFF, "R4");
    unlock(); wr(11'h000, 8'hF0); wr(11'h555, 8'hA0); wr(11'h204, 8'h00);
    rd(11'h204, 8'hFF, 8'hFF, "R4");
    // R5 reset ignored during program
    cur_req = "R5";
    unlock(); wr(11'h555, 8'hA0); wr(11'h300, 8'h3C); wr(11'h555, 8'hF0);
    chk("R5", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(11'h300, 8'hFF, 8'h3C, "R5");
    // R12 protection
    cur_req = "R12";
    unlock(); wr(11'h555, 8'hA0); wr(11'h260, 8'h11); wait_idle();
    set_prot(1, 1);
    unlock(); wr(11'h555, 8'hA0); wr(11'h250, 8'h00);
    chk("R12", {7'b0, busy}, 8'h00);
    rd(11'h250, 8'hFF, 8'hFF, "R12");
    erase_cmd(11'h200);
    chk("R12", {7'b0, busy}, 8'h00);
    rd(11'h260, 8'hFF, 8'h11, "R12");
    // R6 autoselect
    cur_req = "R6";
    unlock(); wr(11'h555, 8'h90);
    rd(11'h000, 8'hFF, MAN, "R6");
    rd(11'h001, 8'hFF, DEV, "R6");
    rd(11'h202, 8'hFF, 8'h01, "R6");
    rd(11'h002, 8'hFF, 8'h00, "R6");
    rd(11'h123, 8'hFF, 8'h00, "R6");
    wr(11'h260, 8'h00);
    rd(11'h401, 8'hFF, DEV, "R6");
    wr(11'h000, 8'hF0);
    rd(11'h260, 8'hFF, 8'h11, "R4");
    // R9 erase with ignored reset
    cur_req = "R9";
    erase_cmd(11'h010);
    chk("R9", {7'b0, busy}, 8'h01);
    repeat (100) @(negedge clk);
    wr(11'h555, 8'hF0);
    chk("R5", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(11'h123, 8'hFF, 8'hFF, "R9");
    rd(11'h300, 8'hFF, 8'h3C, "R9");
    // R10 / R11 suspend
    cur_req = "R10";
    unlock(); wr(11'h555, 8'hA0); wr(11'h5F0, 8'h00); wait_idle();
    unlock(); wr(11'h555, 8'hA0); wr(11'h600, 8'hF0); wait_idle();
    erase_cmd(11'h400);
    repeat (50) @(negedge clk);
    wr(11'h000, 8'hB0);
    chk("R10", {7'b0, busy}, 8'h00);
    rd(11'h400, 8'hBF, 8'h80, "R10");
    b6 = rd_data[6];
    rd(11'h401, 8'hFF, {1'b1, b6, 6'b0}, "R10");
    rd(11'h600, 8'hFF, 8'hF0, "R10");
    cur_req = "R11";
    unlock(); wr(11'h555, 8'hA0); wr(11'h601, 8'h42);
    chk("R11", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(11'h601, 8'hFF, 8'h42, "R11");
    rd(11'h410, 8'hBF, 8'h80, "R11");
    cur_req = "R10";
    unlock(); wr(11'h555, 8'hA0); wr(11'h420, 8'h00);
    chk("R10", {7'b0, busy}, 8'h00);
    wr(11'h123, 8'h30);
    chk("R10", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(11'h5F0, 8'hFF, 8'hFF, "R10");
    rd(11'h420, 8'hFF, 8'hFF, "R10");
    rd(11'h600, 8'hFF, 8'hF0, "R10");
    // R12 unprotect then erase
    cur_req = "R12";
    set_prot(1, 0);
    erase_cmd(11'h3FF);
    chk("R12", {7'b0, busy}, 8'h01);
    wait_idle();
    rd(11'h260, 8'hFF, 8'hFF, "R12");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule